// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one parallel character into one asynchronous serial frame on a single output line. A frame begins with a start bit at 0, carries 5 to 8 data bits with the least significant bit first, may add a parity bit, and ends with one, one and a half, or two stop bits at 1. The line rests at 1 between frames. Timing comes from a 16x oversampling tick enable, and each full bit stays on the line for 16 ticks.

A character is accepted through a valid/ready handshake, and only while the block is idle. The frame format is read from a set of line control inputs at the moment of acceptance. Changes to these inputs during a frame therefore only affect the next character. A separate break input drives the line low while it is held. It does not pause or alter the serializer, which keeps its count, so a frame that runs under break still ends on time.

Top module: `serial_frame_tx`

## Requirements
- R1: Each frame sends a start bit of 0 first, then the data bits least significant first. The word size is set by `lc_word`: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8.
- R2: Each full bit lasts exactly 16 cycles in which `tick_en` is high. Cycles with `tick_en` low do not move the frame forward.
- R3: With `lc_stop` at 0 the frame ends with one stop bit of 1. With `lc_stop` at 1 and a 6, 7 or 8 bit word it ends with two stop bits.
- R4: With `lc_stop` at 1 and a 5-bit word the frame ends with one and a half stop bits, which is 16 ticks plus 8 ticks at 1.
- R5: With `lc_par_en` at 1 and `lc_par_stick` at 0, a parity bit follows the last data bit. With `lc_par_even` at 0 the data bits plus the parity bit hold an odd number of ones. With `lc_par_even` at 1 they hold an even number.
- R6: With `lc_par_en` and `lc_par_stick` both at 1, the parity bit is 0 when `lc_par_even` is 1 and 1 when `lc_par_even` is 0, whatever the data is.
- R7: While `lc_break` is 1, `ser_out` is 0. The frame underneath keeps its timing and its bit values for when break is released.
- R8: The word size, stop and parity settings are taken when a character is accepted. Changes made during a frame do not alter that frame.
- R9: `tx_ready` and `idle` are 1 only when no frame is in progress. A character is taken in the cycle where `tx_valid` and `tx_ready` are both 1. While idle and not in break, `ser_out` is 1.
- R10: After synchronous reset, `idle` and `tx_ready` are 1 and `ser_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 16x oversampling tick enable |
| tx_data | input | 8 | Character to send; the low bits are used for shorter words |
| tx_valid | input | 1 | A character is offered |
| tx_ready | output | 1 | The block can accept a character |
| lc_word | input | 2 | Data word size select (5 + value bits) |
| lc_stop | input | 1 | Extended stop select |
| lc_par_en | input | 1 | Parity enable |
| lc_par_even | input | 1 | Even parity select |
| lc_par_stick | input | 1 | Fixed parity value select |
| lc_break | input | 1 | Force the line low |
| ser_out | output | 1 | Serial line output |
| idle | output | 1 | No frame in progress |

## Verification
The bench goes after the one and a half stop case. A design that treated it as two stop bits, or as one, would end the frame 8 ticks late or 8 ticks early, and the tick count would not match. All four parity modes are run over every word size. Odd and even parity that were swapped, or a fixed parity bit that was inverted, would flip the parity bit. Data of all ones and random data show a parity calculation that reaches past the word size. The line control inputs are scrambled during frames, so a design that read them live would change the length or the bits of a frame in flight. Break is toggled at random during frames: a break that stalled or reset the serializer would lengthen the frame, and a break that leaked into the shift register would corrupt bits sent after it is released.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

    localparam int DATA_MAX = 8;
    localparam int FRAME_W  = 1 + DATA_MAX + 1 + 2;

    typedef struct packed {
        logic [1:0] wsel;
        logic       ext_stop;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
    } fmt_t;

    function automatic int unsigned word_len(input logic [1:0] wsel);
        return 5 + int'(wsel);
    endfunction

    function automatic logic parity_bit(input fmt_t f, input logic [DATA_MAX-1:0] d);
        logic x;
        x = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (i < int'(word_len(f.wsel))) x = x ^ d[i];
        end
        if (f.par_stick) return ~f.par_even;
        return f.par_even ? x : ~x;
    endfunction

    function automatic int unsigned full_bits(input fmt_t f);
        int unsigned n;
        n = 1 + word_len(f.wsel) + (f.par_en ? 1 : 0);
        n = n + ((f.ext_stop && f.wsel != 2'd0) ? 2 : 1);
        return n;
    endfunction

    function automatic logic has_half_stop(input fmt_t f);
        return f.ext_stop && (f.wsel == 2'd0);
    endfunction

endpackage

// File: rtl/sftx_frame_build.sv
module sftx_frame_build
    import sftx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int TW  = 8
) (
    input  fmt_t                      fmt,
    input  logic [DATA_MAX-1:0]       data,
    output logic [FRAME_W-1:0]        frame,
    output logic [TW-1:0]             ticks
);
    int unsigned len;

    always_comb begin
        len   = word_len(fmt.wsel);
        frame = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (i < int'(len)) frame[1 + i] = data[i];
        end
        if (fmt.par_en) frame[1 + len] = parity_bit(fmt, data);
        ticks = TW'(full_bits(fmt) * OVS + (has_half_stop(fmt) ? OVS / 2 : 0));
    end

endmodule

// File: rtl/sftx_tick_seq.sv
module sftx_tick_seq
    import sftx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int TW  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_en,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [TW-1:0]      ticks_in,
    output logic               busy,
    output logic               line_bit
);
    localparam int PW = (OVS > 2) ? $clog2(OVS) : 1;
    localparam logic [PW-1:0] LAST_PHASE = PW'(OVS - 1);

    logic [FRAME_W-1:0] shreg;
    logic [PW-1:0]      phase;
    logic [TW-1:0]      left;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            shreg <= '1;
            phase <= '0;
            left  <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            shreg <= frame_in;
            phase <= '0;
            left  <= ticks_in;
        end else if (busy && tick_en) begin
            left <= left - TW'(1);
            if (left == TW'(1)) busy <= 1'b0;
            if (phase == LAST_PHASE) begin
                phase <= '0;
                shreg <= {1'b1, shreg[FRAME_W-1:1]};
            end else begin
                phase <= phase + PW'(1);
            end
        end
    end

    assign line_bit = shreg[0];

endmodule

// File: rtl/sftx_line_out.sv
module sftx_line_out (
    input  logic busy,
    input  logic line_bit,
    input  logic brk,
    output logic ser_out
);
    always_comb begin
        if (brk)       ser_out = 1'b0;
        else if (busy) ser_out = line_bit;
        else           ser_out = 1'b1;
    end
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import sftx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    input  logic [1:0] lc_word,
    input  logic       lc_stop,
    input  logic       lc_par_en,
    input  logic       lc_par_even,
    input  logic       lc_par_stick,
    input  logic       lc_break,
    output logic       ser_out,
    output logic       idle
);
    localparam int TW = $clog2(OVS * FRAME_W + 1);

    fmt_t               live_fmt;
    logic [FRAME_W-1:0] frame;
    logic [TW-1:0]      ticks;
    logic               busy;
    logic               line_bit;
    logic               load;

    assign live_fmt = '{wsel: lc_word, ext_stop: lc_stop, par_en: lc_par_en,
                        par_even: lc_par_even, par_stick: lc_par_stick};
    assign load     = tx_valid && !busy;
    assign tx_ready = !busy;
    assign idle     = !busy;

    sftx_frame_build #(.OVS(OVS), .TW(TW)) u_build (
        .fmt   (live_fmt),
        .data  (tx_data),
        .frame (frame),
        .ticks (ticks)
    );

    sftx_tick_seq #(.OVS(OVS), .TW(TW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .load     (load),
        .frame_in (frame),
        .ticks_in (ticks),
        .busy     (busy),
        .line_bit (line_bit)
    );

    sftx_line_out u_out (
        .busy     (busy),
        .line_bit (line_bit),
        .brk      (lc_break),
        .ser_out  (ser_out)
    );

endmodule

// File: rtl/sftx_chk.sv
module sftx_chk (
    input logic clk,
    input logic rst,
    input logic tick_en,
    input logic tx_valid,
    input logic tx_ready,
    input logic lc_break,
    input logic ser_out,
    input logic idle
);
    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> (lc_break || !ser_out)); // R1

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !idle && !lc_break) |=> (!idle && (lc_break || $stable(ser_out)))); // R2

    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
        lc_break |-> !ser_out); // R7

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (idle && !lc_break) |-> ser_out); // R9

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (idle && !tx_valid) |=> idle); // R9

    AST_READY_MATCH: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> (!tx_ready && !idle)); // R9
endmodule

bind serial_frame_tx sftx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .lc_break (lc_break),
    .ser_out  (ser_out),
    .idle     (idle)
);

// File: tb/sim_serial_frame_tx.sv
module sim_serial_frame_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [1:0] lc_word = '0;
    logic       lc_stop = 1'b0;
    logic       lc_par_en = 1'b0;
    logic       lc_par_even = 1'b0;
    logic       lc_par_stick = 1'b0;
    logic       lc_break = 1'b0;
    logic       ser_out;
    logic       idle;

    int checks = 0;
    int fails  = 0;
    bit tick_rand = 1'b0;

    always #2 clk = ~clk;

    serial_frame_tx u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .lc_word(lc_word),
        .lc_stop(lc_stop), .lc_par_en(lc_par_en), .lc_par_even(lc_par_even),
        .lc_par_stick(lc_par_stick), .lc_break(lc_break),
        .ser_out(ser_out), .idle(idle)
    );

    always @(posedge clk) begin
        if (rst) tick_en <= 1'b0;
        else if (!tick_rand) tick_en <= 1'b1;
        else tick_en <= (($urandom % 3) == 0);
    end

    function automatic int exp_ticks(input logic [1:0] w, input logic s, input logic pe);
        int len;
        len = 5 + int'(w);
        return 16 * (1 + len + (pe ? 1 : 0) + (s ? (len == 5 ? 1 : 2) : 1))
               + ((s && len == 5) ? 8 : 0);
    endfunction

    function automatic logic exp_bit(input logic [7:0] d, input logic [1:0] w,
                                     input logic pe, input logic pv, input logic ps,
                                     input int idx);
        int len;
        int ones;
        len = 5 + int'(w);
        if (idx == 0) return 1'b0;
        if (idx <= len) return d[idx-1];
        if (pe && idx == len + 1) begin
            if (ps) return !pv;
            ones = 0;
            for (int i = 0; i < len; i++) ones += int'(d[i]);
            return pv ? logic'(ones % 2) : logic'((ones + 1) % 2);
        end
        return 1'b1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input logic [7:0] d, input logic [1:0] w, input logic s,
                             input logic pe, input logic pv, input logic ps,
                             input bit scramble, input bit brk_rand);
        int    nt;
        int    n_exp;
        int    bad;
        int    bad_j;
        int    bad_act;
        int    bad_exp;
        bit    ready_seen;
        logic  e;
        string tag;
        @(negedge clk);
        tx_data = d; lc_word = w; lc_stop = s; lc_par_en = pe;
        lc_par_even = pv; lc_par_stick = ps; lc_break = 1'b0; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        n_exp = exp_ticks(w, s, pe);
        nt = 0; bad = 0; bad_j = 0; bad_act = 0; bad_exp = 0; ready_seen = 1'b0;
        forever begin
            if (scramble) begin
                lc_word = 2'($urandom); lc_stop = 1'($urandom);
                lc_par_en = 1'($urandom); lc_par_even = 1'($urandom);
                lc_par_stick = 1'($urandom); tx_data = 8'($urandom);
            end
            if (brk_rand && ($urandom % 10) == 0) lc_break = ~lc_break;
            #1;
            if (idle) break;
            if (tx_ready) ready_seen = 1'b1;
            if (tick_en) begin
                e = lc_break ? 1'b0 : exp_bit(d, w, pe, pv, ps, nt / 16);
                if (ser_out !== e) begin
                    if (bad == 0) begin
                        bad_j = nt; bad_act = int'(ser_out); bad_exp = int'(e);
                    end
                    bad++;
                end
                nt++;
            end
            @(negedge clk);
        end
        lc_break = 1'b0;
        if (brk_rand)             tag = "R7";
        else if (scramble)        tag = "R8";
        else if (pe && ps)        tag = "R6";
        else if (pe)              tag = "R5";
        else if (s && w == 2'd0)  tag = "R4";
        else if (s)               tag = "R3";
        else                      tag = "R1";
        check(nt == n_exp, (s && w == 2'd0) ? "R4" : (s ? "R3" : "R2"),
              $sformatf("%s frame length in ticks", tag), nt, n_exp);
        check(bad == 0, tag, $sformatf("line value at tick %0d", bad_j), bad_act, bad_exp);
        check(!ready_seen, "R9", "tx_ready low during frame", int'(ready_seen), 0);
        #1;
        check(ser_out === 1'b1 && tx_ready === 1'b1, "R9", "idle line and ready",
              int'(ser_out), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        check(idle === 1'b1, "R10", "idle after reset", int'(idle), 1);
        check(tx_ready === 1'b1, "R10", "tx_ready after reset", int'(tx_ready), 1);
        check(ser_out === 1'b1, "R10", "ser_out after reset", int'(ser_out), 1);

        for (int w = 0; w < 4; w++) begin
            for (int s = 0; s < 2; s++) begin
                for (int pm = 0; pm < 5; pm++) begin
                    logic [7:0] d;
                    d = (pm % 2 == 0) ? 8'hFF : 8'($urandom);
                    run_frame(d, 2'(w), 1'(s), pm != 0, pm == 2 || pm == 4,
                              pm >= 3, 1'b0, 1'b0);
                end
            end
        end
        tick_rand = 1'b1;
        run_frame(8'h00, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame(8'h00, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        run_frame(8'hE0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 30; k++)
            run_frame(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), 1'($urandom), 1'b1, 1'b0);
        for (int k = 0; k < 15; k++)
            run_frame(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), 1'($urandom), 1'b0, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule